// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps a small set of recent virtual-to-physical page translations and answers a lookup for every memory reference in the same cycle the reference is presented. A lookup carries a virtual page number and an access kind: read, write or instruction fetch. The block answers with a hit flag, the physical frame number, the entry's current reference and dirty status, and a protection fault when a store targets a page whose entry withholds write permission. Pages are 8 KB, so only the page number above the 13-bit offset is translated. The offset bits never enter the block.

Any translation may sit in any of the 48 entries. A privileged control port loads a translation, removes the translation for one page, or empties the whole buffer in one cycle so that an address-space switch is cheap. On a load, the hardware picks the slot itself. Entries already holding the same page are reused. Empty slots come next. Otherwise the slot is any entry other than the one most recently hit. Completed references set an entry's reference bit, and completed stores also set its dirty bit. Serving a miss from memory is left to the surrounding logic.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is empty, so every lookup misses.
- R2: A lookup with `probeValid` high whose page number matches a valid entry raises `probeHit` and presents that entry's frame on `probePfn` in the same cycle. On a miss, or while `probeValid` is low, `probeHit`, `probeFault`, `probeRef` and `probeDirty` are 0 and `probePfn` is zero.
- R3: `probeKind` encodes 2'b00 read, 2'b01 write and 2'b10 fetch, and 2'b11 acts as a read. A write that hits an entry loaded with `fillWritable` low raises `probeFault` together with `probeHit`. Such a store does not complete and sets neither status bit. Reads and fetches never fault.
- R4: A write that hits without a fault sets the entry's dirty bit, which a later hit reports on `probeDirty`.
- R5: Any hit without a fault sets the entry's reference bit, which a later hit reports on `probeRef`.
- R6: A load whose page number is already present overwrites that same entry with the new frame and permission, and no second copy is made.
- R7: A load of a new page goes to the lowest-numbered empty entry and evicts nothing while an empty entry exists.
- R8: When no entry is empty, a load replaces the lowest-numbered entry that is not the most recently hit one. The most recently hit entry is the one hit in the same cycle if there is a hit, and otherwise the last entry hit in any earlier cycle.
- R9: `dropReq` removes the entry matching `dropVpn`. Later lookups of that page miss, and other entries are unaffected.
- R10: `flushReq` empties every entry in one cycle. A load presented in the same cycle is discarded.
- R11: A load clears the entry's reference and dirty bits. `probeRef` and `probeDirty` show the bits as stored before the current lookup's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probeValid | input | 1 | Lookup strobe |
| probeKind | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| probeVpn | input | 19 | Virtual page number to translate |
| probeHit | output | 1 | Lookup matched a valid entry |
| probeFault | output | 1 | Store to a write-protected page |
| probePfn | output | 19 | Physical frame number of the hit |
| probeRef | output | 1 | Stored reference bit of the hit entry |
| probeDirty | output | 1 | Stored dirty bit of the hit entry |
| fillReq | input | 1 | Load a translation |
| fillVpn | input | 19 | Page number to load |
| fillPfn | input | 19 | Frame number to load |
| fillWritable | input | 1 | Write permission of the loaded entry |
| dropReq | input | 1 | Remove one translation |
| dropVpn | input | 19 | Page number to remove |
| flushReq | input | 1 | Empty all entries |

## Verification
The collision that matters is a lookup hit and a load falling in the same cycle while the buffer is full. The hit in that cycle must count as most recent, even though the registered last-hit points at another entry. The bench sets this up by hitting one entry, then presenting a hit on a second entry together with a load. It then looks up both pages. The first entry must be gone and the second must still hit. A load in the same cycle as a flush is provoked the same way, and is judged by that page missing afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } accKind_e;

  // strobes from the control to the entry storage, one cycle each
  typedef struct packed {
    logic flushAll;
    logic dropOne;
    logic loadOne;
    logic touchHit;
    logic dirtyHit;
  } xlatStrobe_t;

endpackage

// File: rtl/xlat_lowpick.sv
// Lowest-set-bit picker: reports whether any bit is set and the index of the lowest.
module xlat_lowpick #(
  parameter int W  = 48,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

endmodule

// File: rtl/xlat_store.sv
// Entry storage and parallel tag compare (datapath).
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N     = 48,
  parameter int VPN_W = 19,
  parameter int PFN_W = 19,
  parameter int IW    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probeEn,
  input  logic [VPN_W-1:0]  probeVpn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  input  logic              fillWe,
  input  logic [VPN_W-1:0]  dropVpn,
  input  xlatStrobe_t       strobe,
  input  logic [IW-1:0]     loadIdx,
  output logic [N-1:0]      probeMatch,
  output logic [N-1:0]      fillMatch,
  output logic [N-1:0]      validVec,
  output logic [PFN_W-1:0]  hitPfn,
  output logic              hitWe,
  output logic              hitRef,
  output logic              hitDirty
);

  logic [N-1:0]     validQ;
  logic [N-1:0]     wrOkQ;
  logic [N-1:0]     refQ;
  logic [N-1:0]     dirtyQ;
  logic [VPN_W-1:0] tagQ [N];
  logic [PFN_W-1:0] pfnQ [N];
  logic [N-1:0]     dropMatch;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      probeMatch[i] = probeEn && validQ[i] && (tagQ[i] == probeVpn);
      fillMatch[i]  = validQ[i] && (tagQ[i] == fillVpn);
      dropMatch[i]  = validQ[i] && (tagQ[i] == dropVpn);
    end
  end

  // AND-OR read of the (at most one) matching entry
  always_comb begin
    hitPfn   = '0;
    hitWe    = 1'b0;
    hitRef   = 1'b0;
    hitDirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (probeMatch[i]) begin
        hitPfn   = hitPfn | pfnQ[i];
        hitWe    = hitWe | wrOkQ[i];
        hitRef   = hitRef | refQ[i];
        hitDirty = hitDirty | dirtyQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      wrOkQ  <= '0;
      refQ   <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < N; i++) begin
        tagQ[i] <= '0;
        pfnQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (strobe.flushAll) begin
          validQ[i] <= 1'b0;
        end else begin
          if (strobe.dropOne && dropMatch[i]) validQ[i] <= 1'b0;
          if (strobe.touchHit && probeMatch[i]) refQ[i] <= 1'b1;
          if (strobe.dirtyHit && probeMatch[i]) dirtyQ[i] <= 1'b1;
          if (strobe.loadOne && (loadIdx == IW'(i))) begin
            validQ[i] <= 1'b1;
            tagQ[i]   <= fillVpn;
            pfnQ[i]   <= fillPfn;
            wrOkQ[i]  <= fillWe;
            refQ[i]   <= 1'b0;
            dirtyQ[i] <= 1'b0;
          end
        end
      end
    end
  end

  assign validVec = validQ;

endmodule

// File: rtl/xlat_ctrl.sv
// Fault decision, status-update strobes and victim choice (control).
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int N  = 48,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    probeKind,
  input  logic [N-1:0]  probeMatch,
  input  logic          hitWe,
  input  logic          fillReq,
  input  logic          dropReq,
  input  logic          flushReq,
  input  logic [N-1:0]  fillMatch,
  input  logic [N-1:0]  validVec,
  output xlatStrobe_t   strobe,
  output logic [IW-1:0] loadIdx,
  output logic          hit,
  output logic          fault
);

  accKind_e      kindNow;
  logic          isStore;
  logic [IW-1:0] hitIdx;
  logic          dupAny;
  logic [IW-1:0] dupIdx;
  logic          freeAny;
  logic [IW-1:0] freeIdx;
  logic          ageAny;
  logic [IW-1:0] ageIdx;
  logic [N-1:0]  notMru;
  logic          mruNowValid;
  logic [IW-1:0] mruNowIdx;
  logic          lastValidQ;
  logic [IW-1:0] lastIdxQ;

  assign kindNow = accKind_e'(probeKind);
  assign isStore = (kindNow == ACC_WRITE);

  xlat_lowpick #(.W(N), .IW(IW)) u_hitPick (
    .vec(probeMatch), .any(hit), .idx(hitIdx)
  );
  xlat_lowpick #(.W(N), .IW(IW)) u_dupPick (
    .vec(fillMatch), .any(dupAny), .idx(dupIdx)
  );
  xlat_lowpick #(.W(N), .IW(IW)) u_freePick (
    .vec(~validVec), .any(freeAny), .idx(freeIdx)
  );
  xlat_lowpick #(.W(N), .IW(IW)) u_agePick (
    .vec(notMru), .any(ageAny), .idx(ageIdx)
  );

  assign fault = hit && isStore && !hitWe;

  // a hit in this cycle outranks the registered last hit
  assign mruNowValid = hit || lastValidQ;
  assign mruNowIdx   = hit ? hitIdx : lastIdxQ;

  always_comb begin
    notMru = '1;
    for (int i = 0; i < N; i++) begin
      if (mruNowValid && (mruNowIdx == IW'(i))) notMru[i] = 1'b0;
    end
  end

  always_comb begin
    if (dupAny)       loadIdx = dupIdx;
    else if (freeAny) loadIdx = freeIdx;
    else              loadIdx = ageIdx;
  end

  always_comb begin
    strobe          = '0;
    strobe.flushAll = flushReq;
    strobe.dropOne  = dropReq && !flushReq;
    strobe.loadOne  = fillReq && !flushReq && (dupAny || freeAny || ageAny);
    strobe.touchHit = hit && !fault;
    strobe.dirtyHit = hit && isStore && !fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastValidQ <= 1'b0;
      lastIdxQ   <= '0;
    end else if (hit) begin
      lastValidQ <= 1'b1;
      lastIdxQ   <= hitIdx;
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES    = 48,
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 32,
  parameter int PAGE_SHIFT = 13,
  localparam int VPN_W     = VADDR_W - PAGE_SHIFT,
  localparam int PFN_W     = PADDR_W - PAGE_SHIFT,
  localparam int IW        = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probeValid,
  input  logic [1:0]       probeKind,
  input  logic [VPN_W-1:0] probeVpn,
  output logic             probeHit,
  output logic             probeFault,
  output logic [PFN_W-1:0] probePfn,
  output logic             probeRef,
  output logic             probeDirty,
  input  logic             fillReq,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable,
  input  logic             dropReq,
  input  logic [VPN_W-1:0] dropVpn,
  input  logic             flushReq
);

  xlatStrobe_t        strobe;
  logic [IW-1:0]      loadIdx;
  logic [ENTRIES-1:0] probeMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;
  logic               hitWe;

  xlat_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IW(IW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .probeEn(probeValid), .probeVpn(probeVpn),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .fillWe(fillWritable),
    .dropVpn(dropVpn), .strobe(strobe), .loadIdx(loadIdx),
    .probeMatch(probeMatch), .fillMatch(fillMatch), .validVec(validVec),
    .hitPfn(probePfn), .hitWe(hitWe), .hitRef(probeRef), .hitDirty(probeDirty)
  );

  xlat_ctrl #(.N(ENTRIES), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .probeKind(probeKind), .probeMatch(probeMatch), .hitWe(hitWe),
    .fillReq(fillReq), .dropReq(dropReq), .flushReq(flushReq),
    .fillMatch(fillMatch), .validVec(validVec),
    .strobe(strobe), .loadIdx(loadIdx), .hit(probeHit), .fault(probeFault)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 19,
  parameter int PFN_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             probeValid,
  input logic [1:0]       probeKind,
  input logic [VPN_W-1:0] probeVpn,
  input logic             probeHit,
  input logic             probeFault,
  input logic [PFN_W-1:0] probePfn,
  input logic             probeRef,
  input logic             probeDirty,
  input logic             fillReq,
  input logic             dropReq,
  input logic             flushReq
);

  // R2
  miss_pfn_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !probeHit |-> (probePfn == '0) && !probeRef && !probeDirty);

  // R2
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !probeValid |-> !probeHit && !probeFault);

  // R3
  fault_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    probeFault |-> probeHit && (probeKind == 2'b01));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |=> !probeHit);

  // R4
  store_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probeHit && (probeKind == 2'b01) && !probeFault && !fillReq && !dropReq && !flushReq)
    |=> (!(probeHit && (probeVpn == $past(probeVpn))) || probeDirty));

  // R5
  ref_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (probeHit && !probeFault && !fillReq && !dropReq && !flushReq)
    |=> (!(probeHit && (probeVpn == $past(probeVpn))) || probeRef));

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .probeValid(probeValid), .probeKind(probeKind),
  .probeVpn(probeVpn), .probeHit(probeHit), .probeFault(probeFault),
  .probePfn(probePfn), .probeRef(probeRef), .probeDirty(probeDirty),
  .fillReq(fillReq), .dropReq(dropReq), .flushReq(flushReq)
);

// File: tb/xlat_cache_tb.sv
module xlat_cache_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 19;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, FE = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic probeValid = 1'b0;
  logic [1:0] probeKind = RD;
  logic [VW-1:0] probeVpn = '0;
  logic probeHit, probeFault, probeRef, probeDirty;
  logic [VW-1:0] probePfn;
  logic fillReq = 1'b0;
  logic [VW-1:0] fillVpn = '0;
  logic [VW-1:0] fillPfn = '0;
  logic fillWritable = 1'b0;
  logic dropReq = 1'b0;
  logic [VW-1:0] dropVpn = '0;
  logic flushReq = 1'b0;

  logic rideFill = 1'b0;
  logic [VW-1:0] rideVpn = '0;
  logic [VW-1:0] ridePfn = '0;
  logic rideWe = 1'b0;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  typedef struct {
    logic hit;
    logic [VW-1:0] pfn;
    logic fault;
    logic rf;
    logic dt;
    string req;
  } exp_t;

  exp_t expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .probeValid(probeValid), .probeKind(probeKind), .probeVpn(probeVpn),
    .probeHit(probeHit), .probeFault(probeFault), .probePfn(probePfn),
    .probeRef(probeRef), .probeDirty(probeDirty),
    .fillReq(fillReq), .fillVpn(fillVpn), .fillPfn(fillPfn), .fillWritable(fillWritable),
    .dropReq(dropReq), .dropVpn(dropVpn), .flushReq(flushReq)
  );

  // monitor: compares at the falling edge, between drive and state update
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checkCount++;
        if (probeHit !== e.hit || probePfn !== e.pfn || probeFault !== e.fault ||
            probeRef !== e.rf || probeDirty !== e.dt) begin
          failCount++;
          $display("FAIL %s: hit/pfn/fault/ref/dirty got %0b/%0h/%0b/%0b/%0b expected %0b/%0h/%0b/%0b/%0b",
                   e.req, probeHit, probePfn, probeFault, probeRef, probeDirty,
                   e.hit, e.pfn, e.fault, e.rf, e.dt);
        end
      end
    end
  end

  task automatic releaseAll();
    @(posedge clk); #1;
    probeValid = 1'b0;
    fillReq = 1'b0;
    dropReq = 1'b0;
    flushReq = 1'b0;
    rideFill = 1'b0;
  endtask

  task automatic applyRide();
    if (rideFill) begin
      fillReq = 1'b1;
      fillVpn = rideVpn;
      fillPfn = ridePfn;
      fillWritable = rideWe;
    end
  endtask

  task automatic probe(input logic en, input logic [VW-1:0] vpn, input logic [1:0] kind,
                       input logic eHit, input logic [VW-1:0] ePfn, input logic eFault,
                       input logic eRef, input logic eDirty, input string req);
    exp_t e;
    @(posedge clk); #1;
    probeValid = en;
    probeVpn = vpn;
    probeKind = kind;
    applyRide();
    e.hit = eHit; e.pfn = ePfn; e.fault = eFault; e.rf = eRef; e.dt = eDirty; e.req = req;
    expQ.push_back(e);
    releaseAll();
  endtask

  task automatic hitProbe(input logic [VW-1:0] vpn, input logic [1:0] kind,
                          input logic [VW-1:0] ePfn, input logic eFault,
                          input logic eRef, input logic eDirty, input string req);
    probe(1'b1, vpn, kind, 1'b1, ePfn, eFault, eRef, eDirty, req);
  endtask

  task automatic missProbe(input logic [VW-1:0] vpn, input string req);
    probe(1'b1, vpn, RD, 1'b0, '0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic fill(input logic [VW-1:0] vpn, input logic [VW-1:0] pfn, input logic we);
    @(posedge clk); #1;
    fillReq = 1'b1;
    fillVpn = vpn;
    fillPfn = pfn;
    fillWritable = we;
    releaseAll();
  endtask

  task automatic drop(input logic [VW-1:0] vpn);
    @(posedge clk); #1;
    dropReq = 1'b1;
    dropVpn = vpn;
    releaseAll();
  endtask

  task automatic flushAll();
    @(posedge clk); #1;
    flushReq = 1'b1;
    applyRide();
    releaseAll();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog R1..: got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty after reset
    missProbe(19'h100, "R1");

    fill(19'h100, 19'h11, 1'b1);
    fill(19'h200, 19'h22, 1'b0);

    // R2: gated probe shows nothing even on a present page
    probe(1'b0, 19'h100, RD, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2 idle");
    // R2 / R11: first hit, status cleared by the load
    hitProbe(19'h100, RD, 19'h11, 1'b0, 1'b0, 1'b0, "R2 R11");
    // R5: reference bit now set
    hitProbe(19'h100, RD, 19'h11, 1'b0, 1'b1, 1'b0, "R5");
    hitProbe(19'h100, WR, 19'h11, 1'b0, 1'b1, 1'b0, "R4 store");
    // R4: dirty after completed store
    hitProbe(19'h100, RD, 19'h11, 1'b0, 1'b1, 1'b1, "R4");

    // R3: store to protected page faults, no status change
    hitProbe(19'h200, WR, 19'h22, 1'b1, 1'b0, 1'b0, "R3 fault");
    hitProbe(19'h200, RD, 19'h22, 1'b0, 1'b0, 1'b0, "R3 no status");
    hitProbe(19'h200, FE, 19'h22, 1'b0, 1'b1, 1'b0, "R3 fetch");

    // R6: reload of a present page overwrites it
    fill(19'h200, 19'h33, 1'b1);
    hitProbe(19'h200, WR, 19'h33, 1'b0, 1'b0, 1'b0, "R6 R11");

    // R9: drop one page
    drop(19'h100);
    missProbe(19'h100, "R9");
    hitProbe(19'h200, RD, 19'h33, 1'b0, 1'b1, 1'b1, "R9 other kept");

    // R7: new page fills the freed slot 0, nothing evicted
    fill(19'h300, 19'h44, 1'b1);
    hitProbe(19'h300, RD, 19'h44, 1'b0, 1'b0, 1'b0, "R7");
    hitProbe(19'h200, RD, 19'h33, 1'b0, 1'b1, 1'b1, "R7 kept");
    for (int i = 2; i < 48; i++) fill(19'h1000 + 19'(i), 19'(i), 1'b1);
    hitProbe(19'h102F, RD, 19'h2F, 1'b0, 1'b0, 1'b0, "R7 last slot");
    hitProbe(19'h1002, RD, 19'h02, 1'b0, 1'b0, 1'b0, "R7 slot 2");
    // make slot 1 (page 0x200) the most recently hit
    hitProbe(19'h200, RD, 19'h33, 1'b0, 1'b1, 1'b1, "R8 setup");

    // R8: full, last hit is slot 1, so slot 0 goes
    fill(19'h400, 19'h55, 1'b1);
    missProbe(19'h300, "R8 evicted");
    hitProbe(19'h200, RD, 19'h33, 1'b0, 1'b1, 1'b1, "R8 kept");
    hitProbe(19'h400, RD, 19'h55, 1'b0, 1'b0, 1'b0, "R8 loaded");

    // R8 collision: hit on slot 1 and load in the same cycle, last hit was slot 0
    rideFill = 1'b1; rideVpn = 19'h500; ridePfn = 19'h66; rideWe = 1'b1;
    hitProbe(19'h200, RD, 19'h33, 1'b0, 1'b1, 1'b1, "R8 same-cycle hit");
    missProbe(19'h400, "R8 same-cycle victim");
    hitProbe(19'h500, RD, 19'h66, 1'b0, 1'b0, 1'b0, "R8 same-cycle load");
    // last hit now slot 0, so slot 1 goes
    fill(19'h600, 19'h77, 1'b1);
    missProbe(19'h200, "R8 registered victim");
    hitProbe(19'h600, RD, 19'h77, 1'b0, 1'b0, 1'b0, "R8 registered load");
    hitProbe(19'h500, RD, 19'h66, 1'b0, 1'b1, 1'b0, "R8 registered kept");

    // R10: flush with a load in the same cycle
    rideFill = 1'b1; rideVpn = 19'h700; ridePfn = 19'h0F; rideWe = 1'b1;
    flushAll();
    missProbe(19'h500, "R10");
    missProbe(19'h700, "R10 load dropped");
    missProbe(19'h1005, "R10");
    fill(19'h800, 19'h88, 1'b0);
    hitProbe(19'h800, RD, 19'h88, 1'b0, 1'b0, 1'b0, "R10 refill");
    hitProbe(19'h800, FE, 19'h88, 1'b0, 1'b1, 1'b0, "R3 R5 fetch");
    hitProbe(19'h800, WR, 19'h88, 1'b1, 1'b1, 1'b0, "R3 protected");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule